// File: doc/BRIEF.md
# Eleven-Line Interrupt Aggregator with Message Output

This block gathers up to eleven level-sensitive interrupt lines into three views: an enable register, a pending register that latches new assertions, and a live level register. When an enabled line goes from low to high, the block tells the processor by posting one write. The write carries a data word to a target address, and both come from one programmed target register. The low `MSG_DATA_W` bits of that register are the data word. The remaining bits, with the low bits forced to zero, are the address.

Software uses a simple register bus to program and service the block. It writes the target register and the enable register. It reads a claim register, which returns the enabled pending bits and clears only those bits in the same access. It can also read the pending register, which returns and clears all pending bits, or the level register, which returns the raw line state. Line positions 0 to 5 are slot lines, 6 is an external line, 10 is a serial-port line, and 7 to 9 are spare. Only the positions in the implemented mask (default 0x5FF) exist, so position 9 always reads as zero.

The message leaves on a valid/ready port. While `msg_valid` is high and `msg_ready` is low, the address and data hold steady. A message is taken on any cycle in which both `msg_valid` and `msg_ready` are high. The block keeps at most one message in flight.

Top module: `irqagg_top`

## Requirements
- R1: Only bit positions set in IMPL_MASK (default 0x5FF, so position 9 is absent) exist. An absent position on `irq_in` or in `reg_wdata` has no effect. Every read returns zero in absent positions and in bits 31:11, except a read of the target register.
- R2: A read of the level register (byte offset 0x10) returns the value `irq_in` had at the clock edge before the read edge. The enable register does not affect it. Reading it clears nothing.
- R3: The enable register (offset 0x04) reads back as written, limited to the implemented bits. A bit value of 1 enables the line. A rising edge on a disabled line is not recorded as pending.
- R4: A read of the claim register (offset 0x08) returns pending AND enable. In the same access it clears exactly those pending bits and leaves the other pending bits set.
- R5: A read of the pending register (offset 0x0C) returns every pending bit and clears all of them. The level register does not change.
- R6: A rising edge on an enabled line, once the block is armed, makes `msg_valid` high after the next clock edge. `msg_addr` is the target value with bits [MSG_DATA_W-1:0] zeroed, and `msg_data` holds only those low bits. All three hold until `msg_ready` is seen high.
- R7: After reset, enable and pending read zero and `msg_valid` is low. No message is sent until the target register (offset 0x00) has been written. Writing the target register arms the block. Edges before that still set pending bits.
- R8: Enabling a line that is already high creates no pending bit and no message.
- R9: A rising edge on an enabled line in the same cycle as a clearing read of claim or pending stays pending after that read.
- R10: An edge that arrives while a message is waiting and `msg_ready` is low is merged into the waiting message. An edge in a cycle where the message is accepted starts a new message on the next cycle.
- R11: A read request returns its data on `reg_rdata`, with `reg_rvalid` high, exactly one cycle later. Writes produce no `reg_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Raw interrupt lines |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 means write, 0 means read |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | DW | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | DW | Read data |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | DW | Message target address |
| msg_data | output | DW | Message data word |

## Verification
The hardest situations to set up are the collisions in a single cycle. One is a fresh edge landing on the same cycle as a clearing read. The other is a fresh edge landing on the same cycle as the message handshake. Directed steps line these up exactly by driving the line change and the read, or the ready, before the same edge. A long random phase with a changing `msg_ready` and a changing enable register then mixes merge, accept and re-fire cases, and a cycle-level model in the bench checks each result.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  // register index = byte address [4:2]
  typedef enum logic [2:0] {
    RG_TARGET = 3'd0,
    RG_ENABLE = 3'd1,
    RG_CLAIM  = 3'd2,
    RG_PEND   = 3'd3,
    RG_LEVEL  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int N_IRQ = 11,
  parameter logic [N_IRQ-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  output logic [N_IRQ-1:0] level_q,
  output logic [N_IRQ-1:0] rise
);
  logic [N_IRQ-1:0] live;

  assign live = irq_in & IMPL_MASK;
  assign rise = live & ~level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= live;
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int N_IRQ = 11,
  parameter logic [N_IRQ-1:0] IMPL_MASK = 11'h5FF,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic             reg_rvalid,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_IRQ-1:0] level_q,
  input  logic [N_IRQ-1:0] rise,
  output logic [N_IRQ-1:0] enable_q,
  output logic [DW-1:0]    target_q,
  output logic             armed_q,
  output logic             fire
);
  localparam int IW = AW - 2;

  logic [N_IRQ-1:0] pend_q, clr, hit;
  logic [IW-1:0]    idx;
  logic             rd, wr;
  logic [N_IRQ-1:0] rd_small;
  logic [DW-1:0]    rd_word;

  assign idx  = reg_addr[AW-1:2];
  assign rd   = reg_req & ~reg_we;
  assign wr   = reg_req & reg_we;
  assign hit  = rise & enable_q;
  assign fire = armed_q & (|hit);

  always_comb begin
    clr = '0;
    if (rd && idx == IW'(RG_CLAIM)) clr = pend_q & enable_q;
    if (rd && idx == IW'(RG_PEND))  clr = pend_q;
  end

  always_comb begin
    rd_small = '0;
    case (idx)
      IW'(RG_ENABLE): rd_small = enable_q;
      IW'(RG_CLAIM):  rd_small = pend_q & enable_q;
      IW'(RG_PEND):   rd_small = pend_q;
      IW'(RG_LEVEL):  rd_small = level_q;
      default:        rd_small = '0;
    endcase
    rd_word = {{(DW-N_IRQ){1'b0}}, rd_small};
    if (idx == IW'(RG_TARGET)) rd_word = target_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      enable_q   <= '0;
      target_q   <= '0;
      armed_q    <= 1'b0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      pend_q     <= (pend_q & ~clr) | hit;
      reg_rvalid <= rd;
      if (rd) reg_rdata <= rd_word;
      if (wr && idx == IW'(RG_TARGET)) begin
        target_q <= reg_wdata;
        armed_q  <= 1'b1;
      end
      if (wr && idx == IW'(RG_ENABLE))
        enable_q <= reg_wdata[N_IRQ-1:0] & IMPL_MASK;
    end
  end
endmodule

// File: rtl/irqagg_msg.sv
module irqagg_msg #(
  parameter int DW = 32,
  parameter int MSG_DATA_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] target_q,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [DW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  localparam logic [DW-1:0] LOW_MASK = {{(DW-MSG_DATA_W){1'b0}}, {MSG_DATA_W{1'b1}}};

  logic can_load;
  assign can_load = ~msg_valid | msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (fire && can_load) begin
      msg_valid <= 1'b1;
      msg_addr  <= target_q & ~LOW_MASK;
      msg_data  <= target_q & LOW_MASK;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int N_IRQ = 11,
  parameter logic [N_IRQ-1:0] IMPL_MASK = 11'h5FF,
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int MSG_DATA_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic             reg_rvalid,
  output logic [DW-1:0]    reg_rdata,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [DW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);
  logic [N_IRQ-1:0] level_w, rise_w, enable_w;
  logic [DW-1:0]    target_w;
  logic             armed_w, fire_w;

  irqagg_edge #(.N_IRQ(N_IRQ), .IMPL_MASK(IMPL_MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .level_q(level_w), .rise(rise_w)
  );

  irqagg_regs #(.N_IRQ(N_IRQ), .IMPL_MASK(IMPL_MASK), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .level_q(level_w), .rise(rise_w),
    .enable_q(enable_w), .target_q(target_w), .armed_q(armed_w), .fire(fire_w)
  );

  irqagg_msg #(.DW(DW), .MSG_DATA_W(MSG_DATA_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .fire(fire_w), .target_q(target_w),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int N_IRQ = 11,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_req,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_rvalid,
  input logic [DW-1:0]    reg_rdata,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [DW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data,
  input logic             armed,
  input logic [N_IRQ-1:0] enable
);
  // R6: message held until accepted
  a_r6_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R7: nothing leaves before the target is programmed
  a_r7_no_msg_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !msg_valid);

  // R1: absent positions and upper bits read zero
  a_r1_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid && $past(reg_addr[AW-1:2]) != '0 |-> reg_rdata[9] == 1'b0 && reg_rdata[DW-1:N_IRQ] == '0);

  // R4: claim never returns disabled bits
  a_r4_claim_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid && $past(reg_addr[AW-1:2]) == 3'd2 |-> (reg_rdata[N_IRQ-1:0] & ~$past(enable)) == '0);

  // R11: read data follows a read request by one cycle
  a_r11_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we |=> reg_rvalid);
endmodule

bind irqagg_top irqagg_chk #(.N_IRQ(N_IRQ), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .armed(armed_w), .enable(enable_w)
);

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_in = '0;
  logic        reg_req = 1'b0, reg_we = 1'b0, msg_ready = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid, msg_valid;
  logic [31:0] reg_rdata, msg_addr, msg_data;

  int tests = 0, fails = 0;

  localparam logic [10:0] IMPL = 11'h5FF;
  localparam logic [4:0] A_TGT = 5'h00, A_EN = 5'h04, A_CLM = 5'h08, A_PND = 5'h0C, A_LVL = 5'h10;

  // reference model state
  logic [10:0] m_lvl, m_pend, m_en;
  logic [31:0] m_tgt, m_addr, m_data, e_rd;
  logic        m_armed, m_v, e_rv;
  logic [10:0] cur_irq = '0;

  always #4 clk = ~clk;

  irqagg_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [4:0] a);
    case (a[4:2])
      3'd0: return "R11";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R2";
      default: return "R1";
    endcase
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [10:0] irq, input logic req, input logic we,
                      input logic [4:0] a, input logic [31:0] wd, input logic rdy);
    logic [10:0] s, hit, clr, rs;
    logic [31:0] low;
    logic fire;
    irq_in = irq; reg_req = req; reg_we = we; reg_addr = a; reg_wdata = wd; msg_ready = rdy;
    cur_irq = irq;
    @(posedge clk);
    s = irq & IMPL;
    hit = s & ~m_lvl & m_en;
    fire = m_armed && (hit != 0);
    clr = '0; rs = '0;
    e_rv = req && !we;
    case (a[4:2])
      3'd1: rs = m_en;
      3'd2: begin rs = m_pend & m_en; clr = m_pend & m_en; end
      3'd3: begin rs = m_pend; clr = m_pend; end
      3'd4: rs = m_lvl;
      default: rs = '0;
    endcase
    if (!e_rv) clr = '0;
    if (e_rv) e_rd = (a[4:2] == 3'd0) ? m_tgt : {21'd0, rs};
    low = 32'h1F;
    if (fire && (!m_v || rdy)) begin
      m_v = 1'b1; m_addr = m_tgt & ~low; m_data = m_tgt & low;
    end else if (rdy) m_v = 1'b0;
    m_pend = (m_pend & ~clr) | hit;
    if (req && we && a[4:2] == 3'd0) begin m_tgt = wd; m_armed = 1'b1; end
    if (req && we && a[4:2] == 3'd1) m_en = wd[10:0] & IMPL;
    m_lvl = s;
    @(negedge clk);
    check(m_armed ? "R6" : "R7", {31'd0, msg_valid}, {31'd0, m_v});
    if (m_v) begin
      check("R6", msg_addr, m_addr);
      check("R6", msg_data, m_data);
    end
    check("R11", {31'd0, reg_rvalid}, {31'd0, e_rv});
    if (e_rv) check(rd_tag(a), reg_rdata, e_rd);
  endtask

  task automatic idle(input logic rdy);
    step(cur_irq, 1'b0, 1'b0, 5'h0, 32'h0, rdy);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(cur_irq, 1'b1, 1'b1, a, d, 1'b0);
  endtask
  task automatic rd(input logic [4:0] a);
    step(cur_irq, 1'b1, 1'b0, a, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_lvl = '0; m_pend = '0; m_en = '0; m_tgt = '0; m_armed = 0; m_v = 0;
    m_addr = '0; m_data = '0; e_rd = '0; e_rv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    check("R7", {31'd0, msg_valid}, 32'd0);
    rd(A_EN);  check("R7", reg_rdata, 32'h0);
    rd(A_PND); check("R7", reg_rdata, 32'h0);
    // R1: absent position dropped from enable
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN);  check("R1", reg_rdata, 32'h0000_05FF);
    // R7: edge before arming gives pending but no message
    step(11'h001, 0, 0, 0, 0, 0);
    check("R7", {31'd0, msg_valid}, 32'd0);
    rd(A_PND); check("R5", reg_rdata, 32'h1);
    // R6: message formed from target
    wr(A_TGT, 32'hA000_0013);
    step(11'h003, 0, 0, 0, 0, 0);
    check("R6", {31'd0, msg_valid}, 32'd1);
    check("R6", msg_addr, 32'hA000_0000);
    check("R6", msg_data, 32'h0000_0013);
    idle(0); idle(0);
    // R10: merge while waiting
    step(11'h007, 0, 0, 0, 0, 0);
    idle(1);
    check("R10", {31'd0, msg_valid}, 32'd0);
    // R8: enabling a line that is already high
    wr(A_EN, 32'h0);
    step(11'h00F, 0, 0, 0, 0, 0);
    rd(A_PND); check("R5", reg_rdata, 32'h6);
    wr(A_EN, 32'h008);
    idle(0);
    rd(A_PND); check("R8", reg_rdata, 32'h0);
    check("R8", {31'd0, msg_valid}, 32'd0);
    // R9: edge during clearing read survives
    wr(A_EN, 32'h5FF);
    step(11'h01F, 1, 0, A_CLM, 0, 0);
    check("R9", reg_rdata, 32'h0);
    rd(A_PND); check("R9", reg_rdata, 32'h010);
    idle(1);
    // R1: position 9 ignored on input; R2 level view
    step(11'h21F, 0, 0, 0, 0, 0);
    rd(A_LVL); check("R1", reg_rdata, 32'h01F);
    check("R1", {31'd0, msg_valid}, 32'd0);
    // R10: edge in handshake cycle re-fires
    step(11'h25F, 0, 0, 0, 0, 0);
    check("R10", {31'd0, msg_valid}, 32'd1);
    step(11'h2DF, 0, 0, 0, 0, 1);
    check("R10", {31'd0, msg_valid}, 32'd1);
    idle(1);
    check("R10", {31'd0, msg_valid}, 32'd0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] nirq;
      logic [31:0] r;
      logic [4:0] a;
      r = $urandom;
      nirq = cur_irq ^ (11'(1) << ($urandom % 11)) ;
      if (r[3:2] != 0) nirq = cur_irq;
      a = {($urandom % 6) == 5 ? 3'd5 : 3'(($urandom % 5)), 2'b00};
      if (r[9:8] == 0 && a[4:2] == 3'd0 && r[10])
        step(nirq, 1'b1, 1'b1, a, $urandom, r[4]);
      else if (r[9:8] == 0 && a[4:2] == 3'd1)
        step(nirq, 1'b1, 1'b1, a, $urandom, r[4]);
      else
        step(nirq, r[7:6] == 0, 1'b0, a, 32'h0, r[4]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule